// File: doc/BRIEF.md
# EPROM Pulse Programming Sequencer

This block drives the write side of a one-time-programmable code array. A host presents a request made of a mode, an address, a data byte and a one-cycle start strobe. For every accepted request the sequencer holds the address and data on the array bus and produces a fixed burst of 25 active-low program strobes. Each strobe is separated from the next by an idle gap, and a gap also follows the last strobe. The low width and the gap width come from two timer counts. These stand for the long programming pulse and the short settle time between pulses.

There are three write targets: ordinary code bytes, entries of a 32-entry encryption table, and two security bits. Once any security bit is set, the sequencer refuses any further code or table write. It still accepts a write to the remaining security bit. A refused request produces no strobes. It raises an error flag for one cycle instead. An accepted request holds busy high for its whole duration and finishes with a one-cycle done pulse.

Top module: `eprom_pulse_seq`

## Requirements
- R1: Every accepted request produces exactly 25 falling edges on `prog_no`, and `prog_no` is high whenever `busy_o` is low.
- R2: Each low phase of `prog_no` lasts `pulse_cnt_i` clock cycles, where a count of 0 acts as 1. The count is sampled at the accepting edge.
- R3: Each gap, including the one after the 25th pulse, holds `prog_no` high for `gap_cnt_i` cycles, where a count of 0 acts as 1. In total, `busy_o` is high for 25*(P+G) cycles, with P and G the effective counts.
- R4: `busy_o` rises at the clock edge that samples an accepted start, together with the first low strobe. `done_o` is high for exactly one cycle, in the cycle right after the last busy cycle, and `busy_o` is low during that cycle.
- R5: Mode encoding on `mode_i` is 0 = code byte, 1 = table entry, 2 = security bits, 3 = reserved. A table request is accepted only for addresses 0x00 to 0x1F. Any larger address is refused.
- R6: While `lock_o` is non-zero, every code-byte and table-entry request is refused.
- R7: Security requests are always accepted. On completion, `lock_o` takes the OR of its value and `data_i[1:0]` as latched at the start. Bit 0 and bit 1 are the two security bits. Lock bits clear only on reset.
- R8: A refused request, including any reserved-mode request, raises `error_o` for one cycle in the cycle after the start. It keeps `busy_o` low and produces no strobe.
- R9: Throughout a run, `arr_addr_o` and `arr_data_o` hold the address and data latched at the accepting edge.
- R10: A start strobe that arrives while `busy_o` is high is ignored. It causes no error, it does not lengthen the run, and it does not change `lock_o`.
- R11: After reset, `busy_o`, `done_o`, `error_o` and `lock_o` are 0 and `prog_no` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request strobe |
| mode_i | input | 2 | Request target: 0 code, 1 table, 2 security, 3 reserved |
| addr_i | input | 13 | Target address |
| data_i | input | 8 | Byte to program; bits [1:0] select security bits |
| pulse_cnt_i | input | 8 | Strobe low width in cycles (0 treated as 1) |
| gap_cnt_i | input | 8 | Gap width in cycles (0 treated as 1) |
| prog_no | output | 1 | Active-low program strobe to the array |
| arr_addr_o | output | 13 | Latched address to the array |
| arr_data_o | output | 8 | Latched data to the array |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| error_o | output | 1 | One-cycle refusal pulse |
| lock_o | output | 2 | Programmed security bits |

## Verification
The hardest situation to reach is the partly locked state. One security bit is set, and the sequencer must still take a write to the other bit while it turns away code and table writes. The bench reaches this state only through complete 25-pulse security runs. First it sweeps every timer combination from 0 to 3 on code writes and checks the table address bound, all while the lock is still clear. Then it programs bit 0 and sends code, table and bit-1 requests against the half-locked lock. A start strobe injected in the middle of a run checks that a request arriving while busy leaves both the lock and the run length unchanged.

// File: rtl/eps_pkg.sv
package eps_pkg;
  typedef enum logic [1:0] {
    MODE_CODE  = 2'd0,
    MODE_TABLE = 2'd1,
    MODE_SEC   = 2'd2,
    MODE_RSVD  = 2'd3
  } prog_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PULSE = 2'd1,
    ST_GAP   = 2'd2
  } seq_state_e;
endpackage

// File: rtl/eps_timer.sv
module eps_timer #(
  parameter int TMR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [TMR_W-1:0] count_i,
  output logic             expire_o
);
  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (load_i) cnt_q <= (count_i == '0) ? TMR_W'(1) : count_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - TMR_W'(1);
  end

  assign expire_o = (cnt_q == TMR_W'(1));
endmodule

// File: rtl/eps_req_check.sv
module eps_req_check
  import eps_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int TABLE_LAST = 31
) (
  input  logic [1:0]        mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        lock_i,
  output logic              accept_o
);
  logic locked;
  assign locked = |lock_i;

  always_comb begin
    unique case (prog_mode_e'(mode_i))
      MODE_CODE:  accept_o = !locked;
      MODE_TABLE: accept_o = !locked && (32'(addr_i) <= 32'(TABLE_LAST));
      MODE_SEC:   accept_o = 1'b1;
      default:    accept_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/eps_lock.sv
module eps_lock #(
  parameter int SEC_BITS = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                set_i,
  input  logic [SEC_BITS-1:0] bits_i,
  output logic [SEC_BITS-1:0] lock_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lock_o <= '0;
    else if (set_i) lock_o <= lock_o | bits_i;
  end
endmodule

// File: rtl/eprom_pulse_seq.sv
module eprom_pulse_seq
  import eps_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int DATA_W     = 8,
  parameter int TMR_W      = 8,
  parameter int PULSES     = 25,
  parameter int TABLE_LAST = 31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [TMR_W-1:0]  pulse_cnt_i,
  input  logic [TMR_W-1:0]  gap_cnt_i,
  output logic              prog_no,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [DATA_W-1:0] arr_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              error_o,
  output logic [1:0]        lock_o
);
  localparam int IDX_W = $clog2(PULSES + 1);

  seq_state_e        state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [TMR_W-1:0]  pulse_q, gap_q;
  logic [1:0]        mode_q;
  logic              accept, start_ok, start_bad;
  logic              tmr_load, tmr_exp, last_gap_end;
  logic [TMR_W-1:0]  tmr_val;

  eps_req_check #(.ADDR_W(ADDR_W), .TABLE_LAST(TABLE_LAST)) u_check (
    .mode_i  (mode_i),
    .addr_i  (addr_i),
    .lock_i  (lock_o),
    .accept_o(accept)
  );

  assign start_ok  = (state_q == ST_IDLE) && start_i && accept;
  assign start_bad = (state_q == ST_IDLE) && start_i && !accept;
  assign last_gap_end = (state_q == ST_GAP) && tmr_exp && (idx_q == IDX_W'(PULSES));

  assign tmr_load = start_ok
                  || ((state_q == ST_PULSE) && tmr_exp)
                  || ((state_q == ST_GAP) && tmr_exp && !last_gap_end);

  always_comb begin
    unique case (state_q)
      ST_IDLE:  tmr_val = pulse_cnt_i;
      ST_PULSE: tmr_val = gap_q;
      default:  tmr_val = pulse_q;
    endcase
  end

  eps_timer #(.TMR_W(TMR_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (tmr_load),
    .count_i (tmr_val),
    .expire_o(tmr_exp)
  );

  eps_lock #(.SEC_BITS(2)) u_lock (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (last_gap_end && (prog_mode_e'(mode_q) == MODE_SEC)),
    .bits_i(arr_data_o[1:0]),
    .lock_o(lock_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      idx_q      <= '0;
      pulse_q    <= '0;
      gap_q      <= '0;
      mode_q     <= '0;
      arr_addr_o <= '0;
      arr_data_o <= '0;
      done_o     <= 1'b0;
      error_o    <= 1'b0;
    end else begin
      done_o  <= last_gap_end;
      error_o <= start_bad;
      unique case (state_q)
        ST_IDLE: if (start_ok) begin
          state_q    <= ST_PULSE;
          idx_q      <= '0;
          pulse_q    <= pulse_cnt_i;
          gap_q      <= gap_cnt_i;
          mode_q     <= mode_i;
          arr_addr_o <= addr_i;
          arr_data_o <= data_i;
        end
        ST_PULSE: if (tmr_exp) begin
          state_q <= ST_GAP;
          idx_q   <= idx_q + IDX_W'(1);
        end
        default: if (tmr_exp) state_q <= last_gap_end ? ST_IDLE : ST_PULSE;
      endcase
    end
  end

  assign prog_no = (state_q != ST_PULSE);
  assign busy_o  = (state_q != ST_IDLE);
endmodule

// File: rtl/eps_checker.sv
module eps_checker #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [1:0]        mode_i,
  input logic              prog_no,
  input logic [ADDR_W-1:0] arr_addr_o,
  input logic [DATA_W-1:0] arr_data_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              error_o,
  input logic [1:0]        lock_o
);
  assert_strobe_in_busy_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prog_no |-> busy_o);

  assert_done_after_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o));

  assert_lock_refuses_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && (lock_o != 2'b00) && (mode_i == 2'd0 || mode_i == 2'd1))
      |=> error_o && !busy_o);

  assert_lock_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o & $past(lock_o)) == $past(lock_o));

  assert_error_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> !busy_o && prog_no && !done_o);

  assert_bus_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(arr_addr_o) && $stable(arr_data_o));
endmodule

bind eprom_pulse_seq eps_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_eps_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .mode_i    (mode_i),
  .prog_no   (prog_no),
  .arr_addr_o(arr_addr_o),
  .arr_data_o(arr_data_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .error_o   (error_o),
  .lock_o    (lock_o)
);

// File: tb/tb_eprom_pulse_seq.sv
module tb_eprom_pulse_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 25;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = '0;
  logic [12:0] addr = '0;
  logic [7:0]  data = '0;
  logic [7:0]  pcnt = '0, gcnt = '0;
  logic        prog_n, busy, done, err;
  logic [12:0] aaddr;
  logic [7:0]  adata;
  logic [1:0]  lock;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eprom_pulse_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .addr_i(addr), .data_i(data), .pulse_cnt_i(pcnt), .gap_cnt_i(gcnt),
    .prog_no(prog_n), .arr_addr_o(aaddr), .arr_data_o(adata),
    .busy_o(busy), .done_o(done), .error_o(err), .lock_o(lock)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // result of the last run
  int r_falls, r_low, r_busy, r_err, r_done, r_bus_bad, r_done_after;

  task automatic run(input logic [1:0] m, input logic [12:0] a, input logic [7:0] d,
                     input logic [7:0] p, input logic [7:0] g, input bit poke);
    int n;
    bit prev;
    @(negedge clk);
    mode = m; addr = a; data = d; pcnt = p; gcnt = g; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    r_falls = 0; r_low = 0; r_busy = 0; r_err = 0; r_done = 0; r_bus_bad = 0;
    prev = 1'b1; n = 0;
    while (!done && !err && n < 5000) begin
      if (busy) begin
        r_busy++;
        if (aaddr != a || adata != d) r_bus_bad++;
      end
      if (!prog_n) r_low++;
      if (prev && !prog_n) r_falls++;
      prev = prog_n;
      if (poke && n == 7) begin
        mode = 2'd2; data = 8'h03; start = 1'b1;
      end else start = 1'b0;
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    r_err = err; r_done = done;
    @(negedge clk);
    r_done_after = done | busy;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int pe, ge;
    #(CLK_PERIOD * 3);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11", "busy", busy, 0);
    chk("R11", "prog_no", prog_n, 1);
    chk("R11", "done", done, 0);
    chk("R11", "error", err, 0);
    chk("R11", "lock", lock, 0);

    // R1 R2 R3 R4 R9: sweep timer counts on code writes
    for (int p = 0; p < 4; p++) begin
      for (int g = 0; g < 4; g++) begin
        pe = (p == 0) ? 1 : p;
        ge = (g == 0) ? 1 : g;
        run(2'd0, 13'(100 + 4*p + g), 8'(8'hA5 ^ 8'(p*16+g)), 8'(p), 8'(g), 0);
        chk("R1", "falls", r_falls, NP);
        chk("R2", "low cycles", r_low, NP*pe);
        chk("R3", "busy cycles", r_busy, NP*(pe+ge));
        chk("R4", "done", r_done, 1);
        chk("R4", "done single", r_done_after, 0);
        chk("R9", "bus mismatches", r_bus_bad, 0);
      end
    end

    // R5 table bounds
    run(2'd1, 13'h000, 8'h11, 8'd2, 8'd1, 0);
    chk("R5", "table 0x00 done", r_done, 1);
    chk("R5", "table 0x00 falls", r_falls, NP);
    run(2'd1, 13'h01F, 8'h22, 8'd2, 8'd1, 0);
    chk("R5", "table 0x1F done", r_done, 1);
    run(2'd1, 13'h020, 8'h33, 8'd2, 8'd1, 0);
    chk("R5", "table 0x20 error", r_err, 1);
    chk("R8", "table 0x20 falls", r_falls, 0);
    chk("R8", "table 0x20 busy", r_busy, 0);
    chk("R8", "error single", r_done_after, 0);
    @(negedge clk);
    chk("R8", "error cleared", err, 0);

    // R8 reserved mode
    run(2'd3, 13'h005, 8'h01, 8'd1, 8'd1, 0);
    chk("R8", "reserved error", r_err, 1);
    chk("R8", "reserved lock", lock, 0);

    // R10 start during busy ignored
    run(2'd0, 13'h050, 8'h5A, 8'd1, 8'd1, 1);
    chk("R10", "busy cycles", r_busy, NP*2);
    chk("R10", "error seen", r_err, 0);
    chk("R10", "lock", lock, 0);
    chk("R10", "no restart", r_done_after, 0);

    // R7 first security bit
    run(2'd2, 13'h000, 8'h01, 8'd3, 8'd2, 0);
    chk("R7", "sec0 falls", r_falls, NP);
    chk("R7", "sec0 lock", lock, 1);

    // R6 half lock refuses code and table
    run(2'd0, 13'h010, 8'hFF, 8'd1, 8'd1, 0);
    chk("R6", "code error", r_err, 1);
    chk("R6", "code falls", r_falls, 0);
    run(2'd1, 13'h003, 8'hFF, 8'd1, 8'd1, 0);
    chk("R6", "table error", r_err, 1);
    chk("R6", "table busy", r_busy, 0);

    // R7 other bit still accepted
    run(2'd2, 13'h000, 8'h02, 8'd0, 8'd0, 0);
    chk("R7", "sec1 done", r_done, 1);
    chk("R7", "sec1 busy", r_busy, NP*2);
    chk("R7", "lock both", lock, 3);
    run(2'd2, 13'h000, 8'h00, 8'd1, 8'd1, 0);
    chk("R7", "lock sticky", lock, 3);
    run(2'd0, 13'h000, 8'h00, 8'd1, 8'd1, 0);
    chk("R6", "full lock code error", r_err, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule